// File: doc/BRIEF.md
# Synchronous Offset Gross-Error Detector

This block watches one side of a parallel-bus synchronous data transfer and flags protocol gross errors. It keeps a running count of the outstanding synchronous offset. Each request strobe raises the count, each acknowledge strobe lowers it, and the count is compared against a programmable maximum. It also watches the push and pop handshakes of the local data FIFO against that FIFO's full and empty flags, and it watches the bus phase for changes while data is still owed.

Five causes are told apart: popping an empty FIFO, pushing a full FIFO, an acknowledge at zero offset in target mode, a strobe that would take the offset past the programmed maximum, and a phase change in initiator mode while the offset is nonzero. Any of them sets one sticky gross-error bit, which appears at bit 3 of an interrupt status byte. The first cause is latched as a code. A read-to-clear strobe releases both, and an enable input gates the interrupt request.

Top module: `gerr_det`

## Requirements
- R1: The outstanding offset `off_cnt` rises by one on a cycle with `req_p` and no `ack_p`, falls by one on a cycle with `ack_p` and no `req_p`, and is unchanged when both or neither are high. A rise stops at `max_off` and a fall stops at 0.
- R2: With `max_off` nonzero, a `req_p` without `ack_p` while `off_cnt` >= `max_off` is an offset overflow. It records cause code 4 and leaves `off_cnt` unchanged.
- R3: With `max_off` nonzero and `tgt_mode`=1, an `ack_p` without `req_p` while `off_cnt` is 0 is an offset underflow and records cause code 3. In initiator mode (`tgt_mode`=0) the same stimulus is not an error.
- R4: With `max_off` nonzero and `tgt_mode`=0, a change of `bus_phase` from its value in the previous cycle while `off_cnt` is nonzero records cause code 5. In target mode, or with `off_cnt` at 0, a phase change is not an error.
- R5: `fifo_pop` while `fifo_empty` is high is a data underflow and records cause code 1.
- R6: `fifo_push` while `fifo_full` is high is a data overflow and records cause code 2.
- R7: When `max_off` is 0 (asynchronous transfer), `off_cnt` is held at 0 and causes 3, 4 and 5 never fire.
- R8: `gerr` is sticky. The first recorded `cause` (codes 1 to 5, 0 meaning none) is held, and later causes do not overwrite it. A `clr_rd` pulse clears `gerr` and sets `cause` to 0. If a new cause arrives in the same cycle as `clr_rd`, the new cause is recorded instead.
- R9: When several causes arrive in one cycle, the lowest code is recorded.
- R10: `bus_rst` clears `off_cnt` to 0. `phase_start` while `off_cnt` is 0 keeps it at 0 and overrides that cycle's strobes. `phase_start` while `off_cnt` is nonzero has no effect.
- R11: `irq` is high exactly when `gerr` is high and `irq_en` is high.
- R12: `int_stat` carries `gerr` at bit 3, and all its other bits are 0.
- R13: After reset, `gerr`, `cause`, `irq`, `int_stat` and `off_cnt` are all 0.
- R14: All status and the counter update on the rising clock edge that samples the causing inputs, so the result is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rst | input | 1 | Bus reset: clears the offset count |
| tgt_mode | input | 1 | 1 = target role, 0 = initiator role |
| req_p | input | 1 | Request strobe pulse, one cycle per transfer |
| ack_p | input | 1 | Acknowledge strobe pulse, one cycle per transfer |
| max_off | input | OFF_W | Programmed maximum synchronous offset; 0 means asynchronous |
| phase_start | input | 1 | Start of a new transfer phase |
| bus_phase | input | PH_W | Current bus phase value |
| fifo_push | input | 1 | Write into the local data FIFO |
| fifo_pop | input | 1 | Read from the local data FIFO |
| fifo_full | input | 1 | Local FIFO full flag |
| fifo_empty | input | 1 | Local FIFO empty flag |
| clr_rd | input | 1 | Read-to-clear strobe for the status |
| irq_en | input | 1 | Interrupt enable mask bit |
| gerr | output | 1 | Sticky gross-error status |
| cause | output | 3 | First recorded cause code |
| irq | output | 1 | Interrupt request |
| int_stat | output | 8 | Interrupt status byte, `gerr` at bit 3 |
| off_cnt | output | OFF_W | Outstanding synchronous offset |

## Verification
The hardest situations to reach from the ports are the two offset-based causes at their boundaries. For an offset overflow, the count must be walked exactly to `max_off`. For a phase-change error, a nonzero offset must be left standing in initiator mode while the phase moves. The stimulus builds the offset with a run of request pulses and no acknowledges, then fires the ninth request or a phase change at that point. It then repeats the phase change in target mode and with the offset drained to zero, to show these are not errors. Stickiness and priority are reached by stacking a second cause onto a held one and by firing several causes, or a cause and a clear, in the same cycle.

// File: rtl/gerr_pkg.sv
package gerr_pkg;

  localparam int NUM_CAUSE = 5;
  localparam int GERR_BIT  = 3;

  typedef enum logic [2:0] {
    CZ_NONE   = 3'd0,
    CZ_DUNDER = 3'd1,
    CZ_DOVER  = 3'd2,
    CZ_OUNDER = 3'd3,
    CZ_OOVER  = 3'd4,
    CZ_PHASE  = 3'd5
  } cause_e;

  // bit i of ev maps to code i+1; the lowest set bit wins
  function automatic cause_e pick_cause(input logic [NUM_CAUSE-1:0] ev);
    cause_e c;
    c = CZ_NONE;
    for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
      if (ev[i]) c = cause_e'(3'(i + 1));
    end
    return c;
  endfunction

endpackage

// File: rtl/phase_watch.sv
module phase_watch #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] bus_phase,
  output logic            phase_chg
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= bus_phase;
  end

  assign phase_chg = (bus_phase != phase_q);

endmodule

// File: rtl/fifo_guard.sv
module fifo_guard (
  input  logic fifo_push,
  input  logic fifo_pop,
  input  logic fifo_full,
  input  logic fifo_empty,
  output logic dunder_ev,
  output logic dover_ev
);
  assign dunder_ev = fifo_pop  & fifo_empty;
  assign dover_ev  = fifo_push & fifo_full;
endmodule

// File: rtl/off_tracker.sv
module off_tracker #(
  parameter int OFF_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             phase_start,
  input  logic             tgt_mode,
  input  logic             req_p,
  input  logic             ack_p,
  input  logic [OFF_W-1:0] max_off,
  input  logic             phase_chg,
  output logic [OFF_W-1:0] cnt,
  output logic             oover_ev,
  output logic             ounder_ev,
  output logic             phase_ev
);
  logic sync_mode, up_only, dn_only, cnt_zero, at_limit, restart;

  function automatic logic [OFF_W-1:0] next_off(
    input logic [OFF_W-1:0] cur,
    input logic             up,
    input logic             dn,
    input logic [OFF_W-1:0] lim
  );
    if (up && cur < lim)       return cur + OFF_W'(1);
    else if (dn && cur != '0)  return cur - OFF_W'(1);
    else                       return cur;
  endfunction

  assign sync_mode = |max_off;
  assign up_only   = req_p & ~ack_p;
  assign dn_only   = ack_p & ~req_p;
  assign cnt_zero  = (cnt == '0);
  assign at_limit  = (cnt >= max_off);
  assign restart   = bus_rst | ~sync_mode | (phase_start & cnt_zero);

  assign oover_ev  = sync_mode & up_only & at_limit;
  assign ounder_ev = sync_mode & tgt_mode & dn_only & cnt_zero;
  assign phase_ev  = sync_mode & ~tgt_mode & phase_chg & ~cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= next_off(cnt, up_only, dn_only, max_off);
  end

  // R1
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && up_only && cnt < max_off && !bus_rst && !phase_start)
      |=> (cnt == OFF_W'($past(cnt) + OFF_W'(1))));

  // R2
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oover_ev && !bus_rst) |=> (cnt == $past(cnt)));

  // R7
  async_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> (cnt == '0));

  // R10
  brst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (cnt == '0));

endmodule

// File: rtl/gerr_status.sv
module gerr_status
  import gerr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CAUSE-1:0] ev,
  input  logic                 clr_rd,
  input  logic                 irq_en,
  output logic                 gerr,
  output logic [2:0]           cause,
  output logic                 irq
);
  cause_e cause_q;
  logic   any_ev, take;

  assign any_ev = |ev;
  assign take   = any_ev & (~gerr | clr_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gerr    <= 1'b0;
      cause_q <= CZ_NONE;
    end else if (take) begin
      gerr    <= 1'b1;
      cause_q <= pick_cause(ev);
    end else if (clr_rd) begin
      gerr    <= 1'b0;
      cause_q <= CZ_NONE;
    end
  end

  assign cause = cause_q;
  assign irq   = gerr & irq_en;

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gerr && !clr_rd) |=> (gerr && $stable(cause_q)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !any_ev) |=> (!gerr && cause_q == CZ_NONE));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R8
  none_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gerr |-> (cause_q == CZ_NONE));

endmodule

// File: rtl/gerr_det.sv
module gerr_det
  import gerr_pkg::*;
#(
  parameter int OFF_W = 5,
  parameter int PH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             tgt_mode,
  input  logic             req_p,
  input  logic             ack_p,
  input  logic [OFF_W-1:0] max_off,
  input  logic             phase_start,
  input  logic [PH_W-1:0]  bus_phase,
  input  logic             fifo_push,
  input  logic             fifo_pop,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             clr_rd,
  input  logic             irq_en,
  output logic             gerr,
  output logic [2:0]       cause,
  output logic             irq,
  output logic [7:0]       int_stat,
  output logic [OFF_W-1:0] off_cnt
);
  logic phase_chg, dunder_ev, dover_ev, oover_ev, ounder_ev, phase_ev;
  logic [NUM_CAUSE-1:0] ev_vec;

  phase_watch #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .phase_chg(phase_chg)
  );

  fifo_guard u_fifo (
    .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .dunder_ev(dunder_ev), .dover_ev(dover_ev)
  );

  off_tracker #(.OFF_W(OFF_W)) u_off (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .phase_start(phase_start),
    .tgt_mode(tgt_mode), .req_p(req_p), .ack_p(ack_p), .max_off(max_off),
    .phase_chg(phase_chg), .cnt(off_cnt), .oover_ev(oover_ev),
    .ounder_ev(ounder_ev), .phase_ev(phase_ev)
  );

  // order sets priority: bit 0 is code 1
  assign ev_vec = {phase_ev, oover_ev, ounder_ev, dover_ev, dunder_ev};

  gerr_status u_stat (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr_rd(clr_rd), .irq_en(irq_en),
    .gerr(gerr), .cause(cause), .irq(irq)
  );

  always_comb begin
    int_stat           = '0;
    int_stat[GERR_BIT] = gerr;
  end

  // R5, R9
  dunder_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dunder_ev && !gerr) |=> (gerr && cause == 3'd1));

  // R14
  ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> gerr);

  // R3
  init_no_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_mode |-> !ounder_ev);

  // R4
  tgt_no_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_mode |-> !phase_ev);

endmodule

// File: tb/gerr_det_tb_top.sv
module gerr_det_tb_top;
  localparam int OFF_W = 5;
  localparam int PH_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 0, tgt_mode = 0, req_p = 0, ack_p = 0, phase_start = 0;
  logic [OFF_W-1:0] max_off = 5'd8;
  logic [PH_W-1:0] bus_phase = '0;
  logic fifo_push = 0, fifo_pop = 0, fifo_full = 0, fifo_empty = 0;
  logic clr_rd = 0, irq_en = 1;
  logic gerr, irq;
  logic [2:0] cause;
  logic [7:0] int_stat;
  logic [OFF_W-1:0] off_cnt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int m_cnt = 0, m_cause = 0, m_prev = 0;
  bit m_gerr = 0;

  // scoreboard queues: {gerr, irq, cause[2:0], cnt}
  logic [OFF_W+4:0] exp_q[$];
  string tag_q[$];

  gerr_det #(.OFF_W(OFF_W), .PH_W(PH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .tgt_mode(tgt_mode),
    .req_p(req_p), .ack_p(ack_p), .max_off(max_off), .phase_start(phase_start),
    .bus_phase(bus_phase), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .clr_rd(clr_rd),
    .irq_en(irq_en), .gerr(gerr), .cause(cause), .irq(irq),
    .int_stat(int_stat), .off_cnt(off_cnt)
  );

  always #5 clk = ~clk;

  // driver: inputs already set at a falling edge; predict and queue
  task automatic step(input string tag);
    bit sync_m, up, dn;
    int code;
    sync_m = (max_off != 0);
    up = req_p && !ack_p;
    dn = ack_p && !req_p;
    code = 0;
    if (fifo_pop && fifo_empty) code = 1;
    else if (fifo_push && fifo_full) code = 2;
    else if (sync_m && tgt_mode && dn && m_cnt == 0) code = 3;
    else if (sync_m && up && m_cnt >= int'(max_off)) code = 4;
    else if (sync_m && !tgt_mode && int'(bus_phase) != m_prev && m_cnt != 0) code = 5;
    if (code != 0 && (!m_gerr || clr_rd)) begin
      m_gerr = 1; m_cause = code;
    end else if (clr_rd) begin
      m_gerr = 0; m_cause = 0;
    end
    if (bus_rst || !sync_m || (phase_start && m_cnt == 0)) m_cnt = 0;
    else if (up && m_cnt < int'(max_off)) m_cnt = m_cnt + 1;
    else if (dn && m_cnt > 0) m_cnt = m_cnt - 1;
    m_prev = int'(bus_phase);
    exp_q.push_back({m_gerr, m_gerr & irq_en, 3'(m_cause), OFF_W'(m_cnt)});
    tag_q.push_back(tag);
    @(negedge clk);
    req_p = 0; ack_p = 0; fifo_push = 0; fifo_pop = 0;
    bus_rst = 0; phase_start = 0; clr_rd = 0;
  endtask

  // monitor: compare just after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [OFF_W+4:0] e;
      string t;
      logic [7:0] es;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      es = 8'(e[OFF_W+4]) << 3;
      checks++;
      if (gerr !== e[OFF_W+4] || irq !== e[OFF_W+3] || cause !== e[OFF_W+2:OFF_W]
          || off_cnt !== e[OFF_W-1:0] || int_stat !== es) begin
        errors++;
        $display("FAIL %s (R12 stat): gerr=%0b/%0b irq=%0b/%0b cause=%0d/%0d cnt=%0d/%0d stat=%h/%h",
                 t, gerr, e[OFF_W+4], irq, e[OFF_W+3], cause, e[OFF_W+2:OFF_W],
                 off_cnt, e[OFF_W-1:0], int_stat, es);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13 reset state
    checks++;
    if (gerr !== 0 || cause !== 0 || irq !== 0 || int_stat !== 0 || off_cnt !== 0) begin
      errors++;
      $display("FAIL R13 reset: gerr=%0b cause=%0d irq=%0b stat=%h cnt=%0d expected all 0",
               gerr, cause, irq, int_stat, off_cnt);
    end

    // R1 counting, R14 timing
    repeat (3) begin req_p = 1; step("R1 req up"); end
    req_p = 1; ack_p = 1; step("R1 both hold");
    ack_p = 1; step("R1 ack down");
    // R4 initiator phase change with offset 2
    bus_phase = 3'd2; step("R4 phase change outstanding");
    // R8 later cause does not overwrite
    fifo_push = 1; fifo_full = 1; step("R8 sticky first cause");
    fifo_full = 0;
    clr_rd = 1; step("R8 clear");
    // R11 masking
    irq_en = 0; fifo_pop = 1; fifo_empty = 1; step("R11 masked irq / R5");
    irq_en = 1; step("R11 irq unmasked");
    // R8 clear and new cause together
    clr_rd = 1; fifo_push = 1; fifo_full = 1; step("R8 clear with new cause R6");
    clr_rd = 1; step("R8 clear");
    // R9 simultaneous causes
    fifo_push = 1; fifo_pop = 1; ack_p = 1; step("R9 lowest code wins");
    fifo_full = 0; fifo_empty = 0;
    clr_rd = 1; step("R8 clear");
    // R10 bus reset then R2 overflow at limit 8
    bus_rst = 1; step("R10 bus reset");
    repeat (8) begin req_p = 1; step("R2 fill to limit"); end
    req_p = 1; step("R2 overflow at limit");
    phase_start = 1; step("R10 phase_start nonzero ignored");
    clr_rd = 1; bus_rst = 1; step("R10 bus reset clear");
    phase_start = 1; req_p = 1; step("R10 phase_start at zero overrides req");
    // R3 underflow by mode
    ack_p = 1; step("R3 initiator ack at zero ok");
    tgt_mode = 1; ack_p = 1; step("R3 target ack at zero");
    clr_rd = 1; step("R8 clear");
    // R4 target phase change not an error
    req_p = 1; step("R4 target build offset");
    bus_phase = 3'd5; step("R4 target phase change ok");
    ack_p = 1; step("R1 drain");
    tgt_mode = 0; bus_phase = 3'd1; step("R4 initiator phase change at zero ok");
    // R7 asynchronous mode
    req_p = 1; step("R7 build before async");
    max_off = 5'd0; step("R7 async clears counter");
    repeat (3) begin req_p = 1; step("R7 async req no count"); end
    bus_phase = 3'd6; step("R7 async phase change ok");
    tgt_mode = 1; ack_p = 1; step("R7 async ack no underflow");
    // R5 and R6 alone
    max_off = 5'd8; fifo_pop = 1; fifo_empty = 1; step("R5 pop empty");
    fifo_empty = 0; clr_rd = 1; step("R8 clear");
    fifo_push = 1; fifo_full = 1; step("R6 push full");
    fifo_full = 0; clr_rd = 1; step("R8 clear");
    fifo_push = 1; fifo_pop = 1; step("R5 R6 no error when flags low");

    @(posedge clk); #3;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule